// File: doc/BRIEF.md
# Split-Access 64-bit Control Register Bank

This block is the register slave of an address translation unit. It holds two 64-bit registers, a control word and a table base address, and reserves one flush location that has no state. A simple request port carries an address, a byte count, a write flag and write data. The walker reads both register values continuously from dedicated output ports.

Every register can be written or read whole with an 8-byte access, or one 32-bit half at a time with a 4-byte access. The half ordering is big-endian: the more significant half sits at the register's own offset, and the less significant half sits at offset plus 4. A 32-bit value always travels in bits 31:0 of the data buses. Reset clears both registers, and a control word of zero means translation is disabled.

Top module: `ctlreg_bank`

## Requirements
- R1: After reset, `ctrl_q` and `base_q` are zero, and reads of either register return zero.
- R2: An accepted 8-byte write (`req_size`=8) at 0x00 or 0x08 replaces all 64 bits of the control or base register. The new value appears on `ctrl_q`/`base_q` in the cycle after acceptance.
- R3: An accepted 8-byte read at 0x00 or 0x08 returns all 64 bits of the addressed register on `rsp_rdata`.
- R4: A 4-byte write (`req_size`=4) at 0x00 or 0x08 loads `req_wdata[31:0]` into bits 63:32 of that register and leaves bits 31:0 unchanged.
- R5: A 4-byte write at 0x04 or 0x0C loads `req_wdata[31:0]` into bits 31:0 of that register and leaves bits 63:32 unchanged.
- R6: A 4-byte read at 0x00/0x08 returns the upper half in `rsp_rdata[31:0]`, and one at 0x04/0x0C returns the lower half there. In both cases `rsp_rdata[63:32]` is zero.
- R7: Writes of either size to 0x10, and 4-byte writes to 0x14, change no register. Reads from these locations return zero.
- R8: Any other offset is unmapped: at or above 0x18, an 8-byte access not on an 8-byte boundary, or a 4-byte access not on a 4-byte boundary. A write there changes no register, and a read there returns zero.
- R9: An access whose `req_size` is neither 4 nor 8 is treated as unmapped: a write changes nothing and a read returns zero.
- R10: `req_ready` is always high. `rsp_valid` is high for exactly the one cycle that follows each accepted read, and it stays low after writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_size | input | 4 | Byte count of the access (4 or 8) |
| req_wdata | input | 64 | Write data; a 32-bit write uses bits 31:0 |
| rsp_valid | output | 1 | Read data valid, one cycle after the read is accepted |
| rsp_rdata | output | 64 | Read data; a 32-bit read returns bits 31:0 with the upper bits zero |
| ctrl_q | output | 64 | Current control register value for the walker |
| base_q | output | 64 | Current table base value for the walker |

## Verification
The hardest situation to reach from the ports is a half write that lands between two other updates of the same register. Only that sequence shows whether the untouched half really survives, for example an upper-half write followed by a lower-half write followed by a full read. Random stimulus draws offsets mostly from the handful of mapped and flush locations and draws sizes mostly from 4 and 8, so chains of mixed half and full accesses to one register occur often. Directed sequences open the run with those chains and with misaligned, out-of-range and odd-size accesses. Register outputs are compared against a bench model after every access.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

  localparam int unsigned NREG = 2;
  localparam int unsigned DW   = 64;
  localparam int unsigned HW   = DW / 2;

  typedef enum logic [1:0] {TGT_NONE, TGT_CTRL, TGT_BASE, TGT_FLUSH} tgt_e;
  typedef enum logic [1:0] {PART_NONE, PART_FULL, PART_HI, PART_LO} part_e;

  typedef struct packed {
    tgt_e  tgt;
    part_e part;
  } dec_t;

  // Classify an access by offset and byte count; misaligned or odd sizes map nowhere.
  function automatic dec_t decode_access(input logic [31:0] addr, input logic [3:0] size);
    dec_t d;
    d.tgt  = TGT_NONE;
    d.part = PART_NONE;
    if (size == 4'd8 && addr[2:0] == 3'd0)      d.part = PART_FULL;
    else if (size == 4'd4 && addr[1:0] == 2'd0) d.part = addr[2] ? PART_LO : PART_HI;
    if (d.part != PART_NONE) begin
      case (addr[31:3])
        29'd0:   d.tgt = TGT_CTRL;
        29'd1:   d.tgt = TGT_BASE;
        29'd2:   d.tgt = TGT_FLUSH;
        default: d.tgt = TGT_NONE;
      endcase
    end
    if (d.tgt == TGT_NONE) d.part = PART_NONE;
    return d;
  endfunction

  // Value returned on the data bus for a read of one register.
  function automatic logic [DW-1:0] read_view(input logic [DW-1:0] val, input part_e part);
    case (part)
      PART_FULL: return val;
      PART_HI:   return {{HW{1'b0}}, val[DW-1:HW]};
      PART_LO:   return {{HW{1'b0}}, val[HW-1:0]};
      default:   return '0;
    endcase
  endfunction

endpackage

// File: rtl/ctlreg_decode.sv
module ctlreg_decode
  import ctlreg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              acc,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        size,
  input  logic [DW-1:0]     wdata,
  output dec_t              dec,
  output logic [NREG-1:0]   hi_en,
  output logic [NREG-1:0]   lo_en,
  output logic [HW-1:0]     hi_data,
  output logic [HW-1:0]     lo_data
);
  always_comb begin
    dec = decode_access(32'(addr), size);
    hi_data = (dec.part == PART_FULL) ? wdata[DW-1:HW] : wdata[HW-1:0];
    lo_data = wdata[HW-1:0];
  end

  for (genvar g = 0; g < NREG; g++) begin : g_en
    localparam tgt_e MYTGT = (g == 0) ? TGT_CTRL : TGT_BASE;
    logic hit;
    assign hit      = acc && write && (dec.tgt == MYTGT);
    assign hi_en[g] = hit && (dec.part == PART_FULL || dec.part == PART_HI);
    assign lo_en[g] = hit && (dec.part == PART_FULL || dec.part == PART_LO);
  end
endmodule

// File: rtl/ctlreg_split_reg.sv
module ctlreg_split_reg
  import ctlreg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hi_en,
  input  logic          lo_en,
  input  logic [HW-1:0] hi_data,
  input  logic [HW-1:0] lo_data,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      if (hi_en) q[DW-1:HW] <= hi_data;
      if (lo_en) q[HW-1:0]  <= lo_data;
    end
  end
endmodule

// File: rtl/ctlreg_rsp.sv
module ctlreg_rsp
  import ctlreg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_acc,
  input  dec_t          dec,
  input  logic [DW-1:0] ctrl_val,
  input  logic [DW-1:0] base_val,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);
  logic [DW-1:0] rd_next;

  always_comb begin
    case (dec.tgt)
      TGT_CTRL: rd_next = read_view(ctrl_val, dec.part);
      TGT_BASE: rd_next = read_view(base_val, dec.part);
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_acc;
      if (rd_acc) rsp_rdata <= rd_next;
    end
  end
endmodule

// File: rtl/ctlreg_bank.sv
module ctlreg_bank
  import ctlreg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_size,
  input  logic [63:0]       req_wdata,
  output logic              rsp_valid,
  output logic [63:0]       rsp_rdata,
  output logic [63:0]       ctrl_q,
  output logic [63:0]       base_q
);
  logic            acc;
  dec_t            dec;
  logic [NREG-1:0] wr_hi_en;
  logic [NREG-1:0] wr_lo_en;
  logic [HW-1:0]   hi_data;
  logic [HW-1:0]   lo_data;
  logic [DW-1:0]   reg_q [NREG];

  assign req_ready = 1'b1;
  assign acc       = req_valid && req_ready;

  ctlreg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .acc(acc), .write(req_write), .addr(req_addr), .size(req_size), .wdata(req_wdata),
    .dec(dec), .hi_en(wr_hi_en), .lo_en(wr_lo_en), .hi_data(hi_data), .lo_data(lo_data)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    ctlreg_split_reg u_reg (
      .clk(clk), .rst_n(rst_n), .hi_en(wr_hi_en[g]), .lo_en(wr_lo_en[g]),
      .hi_data(hi_data), .lo_data(lo_data), .q(reg_q[g])
    );
  end

  assign ctrl_q = reg_q[0];
  assign base_q = reg_q[1];

  ctlreg_rsp u_rsp (
    .clk(clk), .rst_n(rst_n), .rd_acc(acc && !req_write), .dec(dec),
    .ctrl_val(reg_q[0]), .base_val(reg_q[1]),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );
endmodule

// File: rtl/ctlreg_bank_chk.sv
module ctlreg_bank_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [3:0]        req_size,
  input logic [63:0]       req_wdata,
  input logic              rsp_valid,
  input logic [63:0]       rsp_rdata,
  input logic [63:0]       ctrl_q,
  input logic [63:0]       base_q,
  input logic [1:0]        wr_hi_en,
  input logic [1:0]        wr_lo_en
);
  logic acc;
  logic odd_size;
  logic flush_adr;
  assign acc       = req_valid && req_ready;
  assign odd_size  = (req_size != 4'd4) && (req_size != 4'd8);
  assign flush_adr = (32'(req_addr) == 32'h10);

  assert_full_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && req_size == 4'd8 && 32'(req_addr) == 32'h0) |=> ctrl_q == $past(req_wdata));

  assert_hi_keeps_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi_en[0] && !wr_lo_en[0]) |=> ctrl_q[31:0] == $past(ctrl_q[31:0]));

  assert_lo_keeps_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo_en[1] && !wr_hi_en[1]) |=> base_q[63:32] == $past(base_q[63:32]));

  assert_half_read_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write && req_size == 4'd4) |=> rsp_rdata[63:32] == 32'h0);

  assert_flush_write_inert_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && flush_adr) |=> ($stable(ctrl_q) && $stable(base_q)));

  assert_one_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({|wr_hi_en, |wr_lo_en} & {2{1'b1}}) || (wr_hi_en == wr_lo_en) || $countones(wr_hi_en | wr_lo_en) == 1);

  assert_odd_size_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write && odd_size) |=> rsp_rdata == 64'h0);

  assert_odd_size_write_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && odd_size) |=> ($stable(ctrl_q) && $stable(base_q)));

  assert_rsp_after_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write) |=> rsp_valid);

  assert_no_rsp_otherwise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && !req_write) |=> !rsp_valid);

  assert_ready_high_R10: assert property (@(posedge clk) disable iff (!rst_n) req_ready);
endmodule

bind ctlreg_bank ctlreg_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ctrl_q(ctrl_q), .base_q(base_q),
  .wr_hi_en(wr_hi_en), .wr_lo_en(wr_lo_en)
);

// File: tb/ctlreg_bank_test.sv
module ctlreg_bank_test;
  localparam int unsigned ADDR_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [3:0]        req_size = 4'd0;
  logic [63:0]       req_wdata = '0;
  logic              rsp_valid;
  logic [63:0]       rsp_rdata;
  logic [63:0]       ctrl_q;
  logic [63:0]       base_q;

  int checks = 0;
  int fails  = 0;
  logic [63:0] m_ctrl = '0;
  logic [63:0] m_base = '0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  ctlreg_bank #(.ADDR_W(ADDR_W)) uut (.*);

  function automatic string tag_of(input int addr, input int size, input bit wr);
    bit full = (size == 8) && (addr % 8 == 0);
    bit half = (size == 4) && (addr % 4 == 0);
    if (size != 4 && size != 8) return "R9";
    if (!(full || half) || addr >= 24) return "R8";
    if (addr >= 16) return "R7";
    if (full) return wr ? "R2" : "R3";
    if (wr) return (addr % 8 == 0) ? "R4" : "R5";
    return "R6";
  endfunction

  // Model of one access: returns expected read data, updates model registers on write.
  function automatic logic [63:0] model(input int addr, input int size, input bit wr, input logic [63:0] d);
    logic [63:0] r;
    bit full = (size == 8) && (addr % 8 == 0);
    bit half = (size == 4) && (addr % 4 == 0);
    if (!(full || half) || addr >= 16) return 64'h0;
    r = (addr < 8) ? m_ctrl : m_base;
    if (wr) begin
      if (full) r = d;
      else if (addr % 8 == 0) r = {d[31:0], r[31:0]};
      else r = {r[63:32], d[31:0]};
      if (addr < 8) m_ctrl = r; else m_base = r;
      return 64'h0;
    end
    if (full) return r;
    return (addr % 8 == 0) ? {32'h0, r[63:32]} : {32'h0, r[31:0]};
  endfunction

  task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic access(input int addr, input int size, input bit wr, input logic [63:0] d);
    logic [63:0] exp;
    string t;
    t = tag_of(addr, size, wr);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = ADDR_W'(addr);
    req_size = 4'(size); req_wdata = d;
    check("R10", "req_ready", {63'h0, req_ready}, 64'h1);
    exp = model(addr, size, wr, d);
    @(negedge clk);
    req_valid = 1'b0;
    check("R10", "rsp_valid", {63'h0, rsp_valid}, {63'h0, !wr});
    if (!wr) check(t, "rsp_rdata", rsp_rdata, exp);
    check(t, "ctrl_q", ctrl_q, m_ctrl);
    check(t, "base_q", base_q, m_base);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    check("R1", "ctrl_q in reset", ctrl_q, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "base_q after reset", base_q, 64'h0);
    check("R10", "idle rsp_valid", {63'h0, rsp_valid}, 64'h0);
    access(0, 8, 0, 0);              // R1 read of cleared control
    access(12, 4, 0, 0);             // R1 read of cleared base half
    // directed chains
    access(0, 8, 1, 64'h0123_4567_89AB_CDEF);   // R2
    access(0, 4, 1, 64'hFFFF_FFFF_1111_2222);   // R4
    access(4, 4, 1, 64'h0000_0000_3333_4444);   // R5
    access(0, 8, 0, 0);                         // R3
    access(0, 4, 0, 0);                         // R6
    access(4, 4, 0, 0);                         // R6
    access(8, 8, 1, 64'hDEAD_BEEF_CAFE_F00D);   // R2
    access(12, 4, 1, 64'h5555_6666_7777_8888);  // R5
    access(8, 4, 1, 64'h0000_0000_9999_AAAA);   // R4
    access(8, 8, 0, 0);                         // R3
    access(16, 8, 1, 64'hFFFF_FFFF_FFFF_FFFF);  // R7
    access(20, 4, 1, 64'hFFFF_FFFF);            // R7
    access(16, 4, 0, 0);                        // R7
    access(20, 4, 0, 0);                        // R7
    access(4, 8, 1, 64'h1);                     // R8 misaligned full
    access(2, 4, 1, 64'h2);                     // R8 misaligned half
    access(24, 8, 1, 64'h3);                    // R8 out of range
    access(200, 4, 0, 0);                       // R8
    access(0, 2, 1, 64'h4);                     // R9
    access(8, 0, 0, 0);                         // R9
    access(0, 15, 0, 0);                        // R9
    // random mix
    for (int i = 0; i < 400; i++) begin
      int a, s, pick;
      pick = $urandom_range(0, 9);
      a = (pick < 8) ? pick * 4 : $urandom_range(0, 255);
      pick = $urandom_range(0, 9);
      s = (pick < 4) ? 4 : (pick < 8) ? 8 : $urandom_range(0, 15);
      access(a, s, $urandom_range(0, 1) == 1, {$urandom, $urandom});
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule